// File: doc/BRIEF.md
# External Clock Sync Qualifier

This block sits beside the switching oscillator of a buck controller and decides, one switching period at a time, whether the oscillator should follow an external synchronisation input. The sync pin arrives already digitised but not yet aligned to the system clock. The block measures the spacing between its falling edges in system-clock counts and compares that spacing with the programmed local period. An edge whose spacing matches a frequency no lower than the local one and at most 40% above it is accepted. A fixed number of clocks later, that edge produces a one-clock cycle-start pulse.

When the pin carries no edges, or the edges fall outside the window, the block produces cycle starts from its own free-running timer at the local period. A lock flag reports whether the most recent cycle start came from the sync input. The flag drops as soon as an edge fails the check. It also drops when no accepted edge arrives within the local period plus a fixed margin; in that case a free-running start is issued at that point.

Top module: `sync_qual_top`

## Requirements
- R1: Only a high-to-low transition of the sync pin counts as an edge; a rising transition neither starts a cycle nor restarts the period measurement.
- R2: An edge is accepted when the count N of clocks since the previous falling edge satisfies 7*N >= 5*P and N <= P, where P is the local period input (for P = 250: N from 179 to 250). Accepted edges then repeat the cycle start every N clocks.
- R3: An edge with N outside that window produces no cycle start, and the lock flag is low from the third clock after the clock in which the pin fell. The block keeps running at the local period P.
- R4: The cycle-start pulse of an accepted edge appears exactly SYNC_STAGES + PHASE_DLY + 1 clocks (7 with the defaults) after the clock in which the pin fell.
- R5: The lock flag rises together with the first cycle start produced by an accepted edge. A single falling edge after reset never sets it, because no period has been measured yet.
- R6: With the pin held at a constant level, cycle starts repeat every P clocks and the lock flag stays low.
- R7: While locked, if P + LOCK_MARGIN clocks (266 with the defaults and P = 250) pass since the last cycle start, a free-running start is issued in that clock and the lock flag falls with it. Starts then repeat every P clocks.
- R8: While reset is high, the cycle-start output and the lock flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pin | input | 1 | External sync level, asynchronous to clk |
| local_period | input | CNT_W | Programmed local switching period in clk counts |
| cycle_start | output | 1 | One-clock pulse that starts an internal switching cycle |
| sync_locked | output | 1 | High while cycle starts follow the sync input |

## Verification
Edge trains are applied at five spacings around P = 250: both window limits (179 and 250), one spacing inside the window, and one spacing just beyond each limit. Together these show where the window boundaries lie and whether they are inclusive. A pin held low shows that the block free-runs without any edges. A train that stops while locked shows where the timeout falls. One short period inserted into a locked train shows that the lock clears on the exact clock the rejection is made and that the rejected edge does not start a cycle. A single edge after reset shows that the first measured period is needed before the block locks.

// File: rtl/sync_qual_pkg.sv
package sync_qual_pkg;

    // Acceptance window on the period: 5/7 * P <= N <= P  (freq. 1.0x .. 1.4x)
    localparam int unsigned WIN_NUM = 5;
    localparam int unsigned WIN_DEN = 7;

    typedef struct packed {
        logic accept;
        logic reject;
    } edge_verdict_t;

    function automatic logic period_in_window(input logic [31:0] meas,
                                              input logic [31:0] ref_p);
        logic [35:0] scaled_meas;
        logic [35:0] scaled_ref;
        scaled_meas = {4'b0, meas} * 36'(WIN_DEN);
        scaled_ref  = {4'b0, ref_p} * 36'(WIN_NUM);
        return (meas <= ref_p) && (scaled_meas >= scaled_ref);
    endfunction

endpackage

// File: rtl/sq_edge_sync.sv
module sq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= pin_i;
        end
    end else begin : g_many
        always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= {stage_q[STAGES-2:0], pin_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= stage_q[STAGES-1];
    end

    assign fall_o = last_q & ~stage_q[STAGES-1];
endmodule

// File: rtl/sq_period_meter.sv
module sq_period_meter
    import sync_qual_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] local_period_i,
    output edge_verdict_t    verdict_o
);
    logic [CNT_W-1:0] span_q;
    logic             seen_q;
    logic             in_win;

    always_comb in_win = period_in_window(32'(span_q), 32'(local_period_i));

    always_comb begin
        verdict_o.accept = fall_i & seen_q & in_win;
        verdict_o.reject = fall_i & seen_q & ~in_win;
    end

    // span_q holds the number of clocks since the last falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            span_q <= '0;
            seen_q <= 1'b0;
        end else if (fall_i) begin
            span_q <= CNT_W'(1);
            seen_q <= 1'b1;
        end else if (span_q != '1) begin
            span_q <= span_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sq_phase_delay.sv
module sq_phase_delay #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_i,
    output logic out_o
);
    if (DLY == 0) begin : g_none
        assign out_o = in_i;
    end else if (DLY == 1) begin : g_single
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= in_i;
        end
        assign out_o = q;
    end else begin : g_chain
        logic [DLY-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= {q[DLY-2:0], in_i};
        end
        assign out_o = q[DLY-1];
    end
endmodule

// File: rtl/sync_qual_top.sv
module sync_qual_top
    import sync_qual_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int PHASE_DLY   = 4,
    parameter int LOCK_MARGIN = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_pin,
    input  logic [CNT_W-1:0] local_period,
    output logic             cycle_start,
    output logic             sync_locked
);
    localparam int LIM_W = CNT_W + 1;

    logic          pin_fall;
    edge_verdict_t verdict;
    logic          sync_start;
    logic          free_start;
    logic [LIM_W-1:0] tmr_q;
    logic [LIM_W-1:0] limit;

    sq_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin_i(sync_pin), .fall_o(pin_fall)
    );

    sq_period_meter #(.CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst), .fall_i(pin_fall),
        .local_period_i(local_period), .verdict_o(verdict)
    );

    sq_phase_delay #(.DLY(PHASE_DLY)) u_delay (
        .clk(clk), .rst(rst), .in_i(verdict.accept), .out_o(sync_start)
    );

    // Locked: allow margin before giving up on the external edge
    always_comb begin
        if (sync_locked) limit = {1'b0, local_period} + LIM_W'(LOCK_MARGIN);
        else             limit = {1'b0, local_period};
        free_start = (tmr_q >= limit) & ~sync_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q       <= '0;
            cycle_start <= 1'b0;
            sync_locked <= 1'b0;
        end else begin
            cycle_start <= sync_start | free_start;
            if (sync_start | free_start) tmr_q <= LIM_W'(1);
            else if (tmr_q != '1)        tmr_q <= tmr_q + LIM_W'(1);
            if (verdict.reject | free_start) sync_locked <= 1'b0;
            else if (sync_start)             sync_locked <= 1'b1;
        end
    end
endmodule

// File: rtl/sync_qual_chk.sv
module sync_qual_chk #(
    parameter int CNT_W       = 16,
    parameter int LOCK_MARGIN = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_start,
    input logic             reject,
    input logic             cycle_start,
    input logic             sync_locked,
    input logic [CNT_W-1:0] local_period
);
    localparam int LIM_W = CNT_W + 1;
    logic [LIM_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)               gap_q <= '0;
        else if (cycle_start)  gap_q <= LIM_W'(1);
        else if (gap_q != '1)  gap_q <= gap_q + LIM_W'(1);
    end

    assert_lock_rises_with_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_locked) |-> cycle_start);

    assert_accepted_edge_starts_R4: assert property (@(posedge clk) disable iff (rst)
        sync_start |=> cycle_start);

    assert_reject_drops_lock_R3: assert property (@(posedge clk) disable iff (rst)
        reject |=> !sync_locked);

    assert_gap_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        gap_q <= ({1'b0, local_period} + LIM_W'(LOCK_MARGIN)));
endmodule

bind sync_qual_top sync_qual_chk #(.CNT_W(CNT_W), .LOCK_MARGIN(LOCK_MARGIN)) u_chk (
    .clk(clk), .rst(rst), .sync_start(sync_start), .reject(verdict.reject),
    .cycle_start(cycle_start), .sync_locked(sync_locked), .local_period(local_period)
);

// File: tb/sync_qual_top_test.sv
module sync_qual_top_test;
    localparam int P   = 250;
    localparam int D   = 4;
    localparam int M   = 16;
    localparam int LAT = D + 3;
    localparam int NV  = 5;
    localparam int VEC_N    [NV] = '{250, 179, 200, 178, 251};
    localparam bit VEC_LOCK [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_pin = 1'b1;
    logic [15:0] local_period = 16'(P);
    logic        cycle_start;
    logic        sync_locked;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;
    int last_start = -1;
    int last_gap = 0;
    int last_fall = 0;

    sync_qual_top #(.CNT_W(16), .SYNC_STAGES(2), .PHASE_DLY(D), .LOCK_MARGIN(M)) uut (
        .clk(clk), .rst(rst), .sync_pin(sync_pin), .local_period(local_period),
        .cycle_start(cycle_start), .sync_locked(sync_locked)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && cycle_start) begin
            if (last_start >= 0) last_gap = cyc - last_start;
            last_start = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sync_pin = 1'b1;
        repeat (3) @(negedge clk);
        check(cycle_start == 1'b0, "R8 start in reset", int'(cycle_start), 0);
        check(sync_locked == 1'b0, "R8 lock in reset", int'(sync_locked), 0);
        last_start = -1;
        last_gap = 0;
        rst = 1'b0;
    endtask

    task automatic send_edges(input int n, input int count);
        for (int k = 0; k < count; k++) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                sync_pin = (i < n / 2) ? 1'b0 : 1'b1;
                if (i == 0) last_fall = cyc;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c;
        int s;
        // Table walk: period window (R2 accept, R3 reject)
        for (int v = 0; v < NV; v++) begin
            do_reset();
            send_edges(VEC_N[v], 4);
            #1;
            if (VEC_LOCK[v]) begin
                check(sync_locked == 1'b1, "R2 lock", int'(sync_locked), 1);
                check(last_gap == VEC_N[v], "R2 gap", last_gap, VEC_N[v]);
                check(last_start == last_fall + LAT, "R1 R4 phase", last_start, last_fall + LAT);
            end else begin
                check(sync_locked == 1'b0, "R3 no lock", int'(sync_locked), 0);
                check(last_gap == P, "R3 local period", last_gap, P);
            end
        end

        // R6: pin held low, no edges
        do_reset();
        sync_pin = 1'b0;
        repeat (3 * P) @(negedge clk);
        #1;
        check(sync_locked == 1'b0, "R6 lock", int'(sync_locked), 0);
        check(last_gap == P, "R6 gap", last_gap, P);

        // R5: one edge alone does not lock
        do_reset();
        send_edges(200, 1);
        #1;
        check(sync_locked == 1'b0, "R5 single edge", int'(sync_locked), 0);

        // R7: edges stop while locked
        do_reset();
        send_edges(200, 3);
        s = last_fall + LAT;
        #1;
        check(sync_locked == 1'b1, "R7 pre lock", int'(sync_locked), 1);
        while (cyc < s + P + M) @(negedge clk);
        #1;
        check(cycle_start == 1'b1, "R7 timeout start", int'(cycle_start), 1);
        check(sync_locked == 1'b0, "R7 lock drop", int'(sync_locked), 0);
        repeat (P + 2) @(negedge clk);
        #1;
        check(last_gap == P, "R7 fallback gap", last_gap, P);

        // R3: short period while locked
        do_reset();
        send_edges(200, 2);
        send_edges(178, 1);
        @(negedge clk);
        sync_pin = 1'b0;
        c = cyc;
        repeat (2) @(negedge clk);
        #1;
        check(sync_locked == 1'b1, "R3 lock before verdict", int'(sync_locked), 1);
        @(negedge clk);
        #1;
        check(sync_locked == 1'b0, "R3 lock after reject", int'(sync_locked), 0);
        repeat (LAT) @(negedge clk);
        #1;
        check(last_start == c - 178 + LAT, "R3 no start from reject", last_start, c - 178 + LAT);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule